// File: doc/BRIEF.md
# Disk Read/Write Bit Sequencer

This block is the bit-level engine of a floppy disk controller. On every enabled step it looks up one 8-bit entry in a fixed 128-entry table. The table is addressed by the two mode bits, the top bit of the 8-bit data latch, the serial read pulse sampled for that step, and the 4-bit sequencer state. The upper nibble of the entry becomes the next state. The lower nibble selects an operation on the latch: clear, hold, shift left inserting 0 or 1, load a byte from the processor, or shift right (or fill with ones when the disk is write protected). Repeated steps assemble read bits into a byte, or move a byte out during writing.

The host first sets the two mode bits, then drives `step` once per sequencer cycle together with the pulse sample. It reads the latch at any time. A window flag gathers whether any step since the last window start did real work. The state and latch can be forced through a load port, so that a saved context can be put back. The read pulse enters as a sample qualified by `step`. There is no ready signal, because the sequencer never stalls: every step consumes its sample in that cycle.

Top module: `disk_seq_core`

## Requirements
- R1: After reset the state, latch and mode are 0, and `acted`, `touched` and `bad_op` are 0.
- R2: When `ld_en` is high, the next edge loads `ld_state` and `ld_latch`, taking priority over `step`. With neither `ld_en` nor `step` high, state and latch hold.
- R3: Operation codes in the low nibble of an entry: 0 clears the latch, 8 holds it, 9 shifts left inserting 0, D shifts left inserting 1, B loads `cpu_data`, and A shifts right inserting 0, or sets the latch to FF when `wp` is high. The high nibble is the next state.
- R4: In read mode (mode 0) with latch bit 7 clear:
  - state 1 goes to state 2 and shifts in a 1;
  - state 9 without a pulse goes to state 2 and shifts in a 0;
  - states 2..9 with a pulse go to state D and hold;
  - state F with a pulse goes to D and shifts in a 1;
  - state D without a pulse goes to 0.
- R5: In read mode with latch bit 7 set:
  - state 1 goes to 3 and holds;
  - state 2 without a pulse stays in 2 and holds;
  - state 2 with a pulse goes to 0;
  - state C without a pulse goes to A and clears the latch.
- R6: In sense mode (q6=1, q7=0), every step goes to state 0 with operation A.
- R7: In the write modes (q7=1), the pulse is ignored and the state advances by one while holding, with these exceptions:
  - states 2 and A shift left inserting 0 when q6=0, or load `cpu_data` when q6=1;
  - state 7 goes to 0 if latch bit 7 is clear, or to 8 if it is set;
  - state F goes to 8 if latch bit 7 is clear, or to 0 if it is set.
- R8: `mode_wr` stores `{q6,q7}` in `mode_q[1:0]`, so the mode index is q6*2+q7. `rd_start` clears both bits and wins over `mode_wr`.
- R9: `acted` is high after a step whose operation was not 8. `touched` is the OR of that over all steps since the last `win_start`; a step in the same cycle as `win_start` counts.
- R10: `bad_op` is set if a step ever uses an operation code outside {0,8,9,A,B,D}. The fixed table never does this.
- R11: In read mode from state 0 with latch 0 and no pulses, the latch reaches 80 on step 58, after which it stays at 80 in state 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Store new mode bits |
| q6_in | input | 1 | New q6 value |
| q7_in | input | 1 | New q7 value |
| rd_start | input | 1 | Return to read mode |
| step | input | 1 | Run one sequencer cycle |
| pulse | input | 1 | Read pulse sample for this step |
| wp | input | 1 | Write-protect sense |
| cpu_data | input | 8 | Byte for the load operation |
| win_start | input | 1 | Start a new activity window |
| ld_en | input | 1 | Force state and latch |
| ld_state | input | 4 | State to force |
| ld_latch | input | 8 | Latch value to force |
| latch_q | output | 8 | Data latch |
| state_q | output | 4 | Sequencer state |
| mode_q | output | 2 | {q6,q7} |
| acted | output | 1 | Last step did a real operation |
| touched | output | 1 | Some step in the window did a real operation |
| bad_op | output | 1 | Sticky illegal-operation flag |

## Verification
Both the state and the latch are outputs, so a wrong table entry shows on `state_q` one edge after the step that used it. A fault in the latch operation shows on `latch_q` at that same edge. Faults in the bit-7 addressing only appear once a byte is nearly assembled, which is why the long no-pulse run checks the latch at step 58 and the steps after it. A flaw in the activity tracking shows on `acted` and `touched` after a single hold step.

// File: rtl/disk_seq_pkg.sv
package disk_seq_pkg;
  localparam int STATE_W = 4;
  localparam int DATA_W  = 8;
  localparam int ENTRY_W = 2 * STATE_W;
  localparam int PAGE_W  = ENTRY_W * (1 << STATE_W);

  typedef enum logic [STATE_W-1:0] {
    OP_CLR  = 4'h0,
    OP_HOLD = 4'h8,
    OP_SHL0 = 4'h9,
    OP_SHR  = 4'hA,
    OP_LOAD = 4'hB,
    OP_SHL1 = 4'hD
  } op_e;

  localparam logic [1:0] MODE_READ  = 2'd0;
  localparam logic [1:0] MODE_SENSE = 2'd2;
endpackage

// File: rtl/seq_mode_reg.sv
module seq_mode_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic       q6_in,
  input  logic       q7_in,
  input  logic       rd_start,
  output logic [1:0] mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        mode_q <= 2'b00;
    else if (rd_start) mode_q <= 2'b00;
    else if (mode_wr)  mode_q <= {q6_in, q7_in};
  end

  AST_RDSTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> (mode_q == 2'b00)); // R8
  AST_MODE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !rd_start) |=> (mode_q == $past({q6_in, q7_in}))); // R8
endmodule

// File: rtl/seq_rom.sv
module seq_rom
  import disk_seq_pkg::*;
(
  input  logic [1:0]         mode,
  input  logic               msb,
  input  logic               pulse,
  input  logic [STATE_W-1:0] state,
  output logic [ENTRY_W-1:0] entry
);
  // read-mode pages, state 0 in the lowest byte
  localparam logic [PAGE_W-1:0] PG_LO_NP = 128'h4dfd08d9_59bd2998_88786858_48382d18;
  localparam logic [PAGE_W-1:0] PG_LO_P  = 128'hddfdd8d9_d9cdd8d8_d8d8d8d8_d8d82d18;
  localparam logic [PAGE_W-1:0] PG_HI_NP = 128'he0f8e8a0_c8b8a898_88786858_48283818;
  localparam logic [PAGE_W-1:0] PG_HI_P  = 128'he0f8e8d8_d8d8d8d8_d8d8d8d8_48083818;

  logic [PAGE_W-1:0]  page;
  logic [STATE_W-1:0] wr_next;
  logic [STATE_W-1:0] wr_op;

  always_comb begin
    unique case ({msb, pulse})
      2'b00:   page = PG_LO_NP;
      2'b01:   page = PG_LO_P;
      2'b10:   page = PG_HI_NP;
      default: page = PG_HI_P;
    endcase
  end

  always_comb begin
    wr_next = state + 1'b1;
    wr_op   = OP_HOLD;
    if (state == 4'd2 || state == 4'd10)
      wr_op = mode[1] ? OP_LOAD : OP_SHL0;
    if (state == 4'd7)  wr_next = msb ? 4'd8 : 4'd0;
    if (state == 4'd15) wr_next = msb ? 4'd0 : 4'd8;
  end

  always_comb begin
    if (mode == MODE_READ)       entry = page[state*ENTRY_W +: ENTRY_W];
    else if (mode == MODE_SENSE) entry = {4'd0, OP_SHR};
    else                         entry = {wr_next, wr_op};
  end
endmodule

// File: rtl/latch_alu.sv
module latch_alu
  import disk_seq_pkg::*;
(
  input  logic [STATE_W-1:0] op,
  input  logic [DATA_W-1:0]  cur,
  input  logic [DATA_W-1:0]  cpu_data,
  input  logic               wp,
  output logic [DATA_W-1:0]  nxt,
  output logic               legal
);
  always_comb begin
    legal = 1'b1;
    nxt   = cur;
    unique case (op)
      OP_CLR:  nxt = '0;
      OP_HOLD: nxt = cur;
      OP_SHL0: nxt = {cur[DATA_W-2:0], 1'b0};
      OP_SHL1: nxt = {cur[DATA_W-2:0], 1'b1};
      OP_LOAD: nxt = cpu_data;
      OP_SHR:  nxt = wp ? '1 : {1'b0, cur[DATA_W-1:1]};
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/disk_seq_core.sv
module disk_seq_core
  import disk_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_wr,
  input  logic               q6_in,
  input  logic               q7_in,
  input  logic               rd_start,
  input  logic               step,
  input  logic               pulse,
  input  logic               wp,
  input  logic [DATA_W-1:0]  cpu_data,
  input  logic               win_start,
  input  logic               ld_en,
  input  logic [STATE_W-1:0] ld_state,
  input  logic [DATA_W-1:0]  ld_latch,
  output logic [DATA_W-1:0]  latch_q,
  output logic [STATE_W-1:0] state_q,
  output logic [1:0]         mode_q,
  output logic               acted,
  output logic               touched,
  output logic               bad_op
);
  logic [ENTRY_W-1:0] entry;
  logic [STATE_W-1:0] op;
  logic [STATE_W-1:0] next_state;
  logic [DATA_W-1:0]  next_latch;
  logic               legal;
  logic               run;
  logic               did_work;

  seq_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .q6_in(q6_in),
    .q7_in(q7_in), .rd_start(rd_start), .mode_q(mode_q)
  );

  seq_rom u_rom (
    .mode(mode_q), .msb(latch_q[DATA_W-1]), .pulse(pulse),
    .state(state_q), .entry(entry)
  );

  assign next_state = entry[ENTRY_W-1:STATE_W];
  assign op         = entry[STATE_W-1:0];

  latch_alu u_alu (
    .op(op), .cur(latch_q), .cpu_data(cpu_data), .wp(wp),
    .nxt(next_latch), .legal(legal)
  );

  assign run      = step && !ld_en;
  assign did_work = (op != OP_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
      latch_q <= '0;
      acted   <= 1'b0;
      touched <= 1'b0;
      bad_op  <= 1'b0;
    end else begin
      if (ld_en) begin
        state_q <= ld_state;
        latch_q <= ld_latch;
      end else if (step) begin
        state_q <= next_state;
        latch_q <= next_latch;
      end
      acted <= run && did_work;
      if (win_start)  touched <= run && did_work;
      else if (run)   touched <= touched || did_work;
      if (run && !legal) bad_op <= 1'b1;
    end
  end

  AST_LOAD_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (state_q == $past(ld_state) && latch_q == $past(ld_latch))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !step) |=> ($stable(state_q) && $stable(latch_q))); // R2
  AST_WP_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == OP_SHR && wp) |=> (latch_q == '1)); // R3
  AST_SENSE_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_q == MODE_SENSE) |=> (state_q == '0)); // R6
  AST_NO_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> legal); // R10
  AST_WIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (win_start && !run) |=> !touched); // R9
endmodule

// File: tb/tb_disk_seq_core.sv
`timescale 1ns/1ps
module tb_disk_seq_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 0, q6_in = 0, q7_in = 0, rd_start = 0;
  logic step = 0, pulse = 0, wp = 0, win_start = 0, ld_en = 0;
  logic [7:0] cpu_data = 8'h00, ld_latch = 8'h00;
  logic [3:0] ld_state = 4'h0;
  logic [7:0] latch_q;
  logic [3:0] state_q;
  logic [1:0] mode_q;
  logic acted, touched, bad_op;

  int nvec = 0;
  int nerr = 0;
  logic pend = 1'b0;

  logic [7:0] q_latch[$];
  logic [3:0] q_state[$];
  logic       q_act[$];
  logic       q_chk[$];
  string      q_req[$];

  always #2.5 clk = ~clk;

  disk_seq_core dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .q6_in(q6_in), .q7_in(q7_in),
    .rd_start(rd_start), .step(step), .pulse(pulse), .wp(wp), .cpu_data(cpu_data),
    .win_start(win_start), .ld_en(ld_en), .ld_state(ld_state), .ld_latch(ld_latch),
    .latch_q(latch_q), .state_q(state_q), .mode_q(mode_q), .acted(acted),
    .touched(touched), .bad_op(bad_op)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per step, one edge later
  always @(posedge clk) pend <= step;
  always @(negedge clk) begin
    if (pend && q_latch.size() > 0) begin
      logic [7:0] el;
      logic [3:0] es;
      logic ea, ck;
      string rq;
      el = q_latch.pop_front(); es = q_state.pop_front();
      ea = q_act.pop_front();   ck = q_chk.pop_front(); rq = q_req.pop_front();
      if (ck) begin
        chk({rq, " latch"}, latch_q, el);
        chk({rq, " state"}, state_q, es);
        chk({rq, " acted"}, acted, ea);
      end
    end
  end

  task automatic do_step(input logic p, input logic w, input logic [7:0] d,
                         input logic ck, input logic [7:0] el, input logic [3:0] es,
                         input logic ea, input string rq);
    @(negedge clk);
    pulse = p; wp = w; cpu_data = d; step = 1'b1;
    q_latch.push_back(el); q_state.push_back(es); q_act.push_back(ea);
    q_chk.push_back(ck); q_req.push_back(rq);
    @(posedge clk); #1 step = 1'b0;
  endtask

  task automatic do_ld(input logic [3:0] s, input logic [7:0] l);
    @(negedge clk);
    ld_en = 1'b1; ld_state = s; ld_latch = l;
    @(posedge clk); #1 ld_en = 1'b0;
  endtask

  task automatic set_mode(input logic a6, input logic a7);
    @(negedge clk);
    mode_wr = 1'b1; q6_in = a6; q7_in = a7;
    @(posedge clk); #1 mode_wr = 1'b0;
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 latch", latch_q, 8'h00);
    chk("R1 state", state_q, 4'h0);
    chk("R1 mode", mode_q, 2'd0);
    chk("R1 flags", {acted, touched, bad_op}, 3'b000);

    // R2 load and hold
    do_ld(4'h5, 8'hA5);
    @(negedge clk);
    chk("R2 ld state", state_q, 4'h5);
    chk("R2 ld latch", latch_q, 8'hA5);
    repeat (3) @(negedge clk);
    chk("R2 idle hold", {state_q, latch_q}, {4'h5, 8'hA5});

    // R11 no-pulse byte assembly from state 0, latch 0
    do_ld(4'h0, 8'h00);
    for (int n = 1; n <= 60; n++) begin
      if (n == 2)       do_step(0, 0, 0, 1, 8'h01, 4'h2, 1, "R11 step2");
      else if (n == 10) do_step(0, 0, 0, 1, 8'h02, 4'h2, 1, "R11 step10");
      else if (n == 58) do_step(0, 0, 0, 1, 8'h80, 4'h2, 1, "R11 step58");
      else if (n >= 59) do_step(0, 0, 0, 1, 8'h80, 4'h2, 0, "R11 hold");
      else              do_step(0, 0, 0, 0, 8'h00, 4'h0, 0, "R11");
    end
    drain();

    // R4 pulse pattern 0,0,1,0,0,0
    do_ld(4'h0, 8'h00);
    do_step(0, 0, 0, 1, 8'h00, 4'h1, 0, "R4 s0");
    do_step(0, 0, 0, 1, 8'h01, 4'h2, 1, "R4 s1");
    do_step(1, 0, 0, 1, 8'h01, 4'hD, 0, "R4 pulse");
    do_step(0, 0, 0, 1, 8'h01, 4'h0, 0, "R4 sD");
    do_step(0, 0, 0, 1, 8'h01, 4'h1, 0, "R4 s0b");
    do_step(0, 0, 0, 1, 8'h03, 4'h2, 1, "R4 s1b");
    drain();
    do_ld(4'h9, 8'h01); do_step(0, 0, 0, 1, 8'h02, 4'h2, 1, "R4 s9");
    do_ld(4'h5, 8'h10); do_step(1, 0, 0, 1, 8'h10, 4'hD, 0, "R4 s5p");
    do_ld(4'hF, 8'h40); do_step(1, 0, 0, 1, 8'h81, 4'hD, 1, "R4 sFp");
    // R5 latch bit 7 set
    do_ld(4'h1, 8'h80); do_step(1, 0, 0, 1, 8'h80, 4'h3, 0, "R5 s1");
    do_ld(4'h2, 8'h81); do_step(1, 0, 0, 1, 8'h81, 4'h0, 0, "R5 s2p");
    do_ld(4'hC, 8'h80); do_step(0, 0, 0, 1, 8'h00, 4'hA, 1, "R5 R3 clear");
    drain();

    // R6 sense mode, R3 write-protect fill
    set_mode(1, 0);
    @(negedge clk); chk("R8 mode sense", mode_q, 2'd2);
    do_ld(4'h7, 8'h84);
    do_step(0, 0, 0, 1, 8'h42, 4'h0, 1, "R6 R3 shr");
    do_step(1, 1, 0, 1, 8'hFF, 4'h0, 1, "R6 R3 wp");
    drain();

    // R7 write mode q6=0
    set_mode(0, 1);
    do_ld(4'h2, 8'h41); do_step(0, 0, 0, 1, 8'h82, 4'h3, 1, "R7 shl0");
    do_ld(4'h7, 8'h00); do_step(0, 0, 0, 1, 8'h00, 4'h0, 0, "R7 s7 lo");
    do_ld(4'h7, 8'h80); do_step(0, 0, 0, 1, 8'h80, 4'h8, 0, "R7 s7 hi");
    do_ld(4'hF, 8'h00); do_step(0, 0, 0, 1, 8'h00, 4'h8, 0, "R7 sF lo");
    do_ld(4'hF, 8'h80); do_step(0, 0, 0, 1, 8'h80, 4'h0, 0, "R7 sF hi");
    do_ld(4'h4, 8'h11); do_step(1, 0, 0, 1, 8'h11, 4'h5, 0, "R7 pulse ignored");
    drain();
    // R7 load mode q6=1
    set_mode(1, 1);
    do_ld(4'hA, 8'h00); do_step(0, 0, 8'h5A, 1, 8'h5A, 4'hB, 1, "R7 R3 load A");
    do_ld(4'h2, 8'hFF); do_step(0, 0, 8'h3C, 1, 8'h3C, 4'h3, 1, "R7 load 2");
    drain();

    // R8 rd_start wins over mode_wr
    @(negedge clk);
    rd_start = 1'b1; mode_wr = 1'b1; q6_in = 1'b1; q7_in = 1'b0;
    @(posedge clk); #1 rd_start = 1'b0; mode_wr = 1'b0;
    @(negedge clk); chk("R8 rd_start", mode_q, 2'd0);

    // R9 activity window
    do_ld(4'h2, 8'h80);
    @(negedge clk); win_start = 1'b1; @(posedge clk); #1 win_start = 1'b0;
    @(negedge clk); chk("R9 window clear", touched, 1'b0);
    do_step(0, 0, 0, 1, 8'h80, 4'h2, 0, "R9 hold");
    do_step(0, 0, 0, 1, 8'h80, 4'h2, 0, "R9 hold2");
    drain();
    chk("R9 touched idle", touched, 1'b0);
    do_ld(4'h9, 8'h01);
    do_step(0, 0, 0, 1, 8'h02, 4'h2, 1, "R9 act");
    drain();
    chk("R9 touched set", touched, 1'b1);
    do_step(0, 0, 0, 1, 8'h02, 4'h3, 0, "R9 after");
    drain();
    chk("R9 touched sticky", touched, 1'b1);
    chk("R10 bad_op", bad_op, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule